// File: doc/BRIEF.md
# Externally Clocked Serial Transmit Queue

This block is the send half of a synchronous serial port working as a slave. The serial clock comes from outside. A host pushes bytes into a four-deep FIFO. The FIFO drains into a one-byte holding buffer, and the buffer reloads an 8-bit shifter. Up to five bytes can therefore wait before the first bit goes out. Bits leave most significant first. The shifter advances once for each falling edge of the external clock, and that edge is seen through a synchroniser in the system clock domain.

The host controls the block through four inputs:
- a transmit-enable bit;
- a transfer-mode code;
- a fill level for the interrupt;
- a command strobe, which can flush the FIFO.

An optional self-stop clears the enable once every stage has drained. With a fill level of zero, the interrupt fires as the last queued byte moves from the FIFO into the buffer.

Top module: `sio_tx_queue`

## Requirements
- R1: After reset, `sdo_o`=1, `buf_empty_o`=1, `tx_en_o`=0, `ovf_o`=0 and `irq_o`=0.
- R2: The FIFO has four entries and feeds a one-byte buffer. When the buffer is empty and the FIFO is not, the head byte moves into the buffer at the next rising edge. Five bytes are therefore held without loss, and `buf_empty_o`=0 while the buffer holds a byte.
- R3: A write while the FIFO holds four entries is dropped, even if a byte leaves the FIFO in that cycle. The dropped write sets `ovf_o`, which stays at 1 until a clear command.
- R4: Bytes go out in write order, MSB first. The shifter loads from the buffer when it is idle and transmission is allowed. `sdo_o` shows bit 7 from that load onward, and advances one bit for each falling edge of `sclk_i`. A byte ends at its eighth falling edge.
- R5: `sclk_i` passes through a two-flop synchroniser and an edge register. A falling edge of `sclk_i` changes `sdo_o` at the third rising clock edge after the falling edge.
- R6: The shifter loads only while `tx_en_o`=1 and `mode_i`=2'b10 (half-duplex transmit). For any other mode code, the buffer keeps its byte and `sdo_o` stays at 1. A byte already shifting finishes in any mode.
- R7: `irq_o` is a one-cycle pulse. It appears in the cycle after a FIFO-to-buffer move that leaves the FIFO count equal to `fill_lvl_i` (range 0 to 4).
- R8: With `auto_dis_i`=1, `tx_en_o` clears on the edge after the FIFO, the buffer and the shifter are all empty. It therefore never clears while a byte is still shifting.
- R9: When `cmd_stb_i`=1 with `cmd_i`=2'b11, the FIFO empties and `ovf_o` clears, and a write in the same cycle is discarded. The buffer and the shifter are not affected. Other command codes have no effect.
- R10: A host write to the enable (`txe_wr_i`=1 loads `txe_val_i`) takes priority over the self-stop.
- R11: `sdo_o` is 1 whenever the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to queue |
| txe_wr_i | input | 1 | Transmit-enable write strobe |
| txe_val_i | input | 1 | Transmit-enable value |
| mode_i | input | 2 | Transfer mode; 2'b10 allows transmission |
| fill_lvl_i | input | 3 | FIFO count that raises the interrupt |
| auto_dis_i | input | 1 | Clear the enable when everything has drained |
| cmd_stb_i | input | 1 | FIFO command strobe |
| cmd_i | input | 2 | FIFO command; 2'b11 clears the FIFO |
| sclk_i | input | 1 | External shift clock |
| sdo_o | output | 1 | Serial data out |
| buf_empty_o | output | 1 | Holding buffer empty |
| tx_en_o | output | 1 | Current transmit enable |
| ovf_o | output | 1 | Sticky write-overflow flag |
| irq_o | output | 1 | Fill-level interrupt pulse |

## Verification
The assertions check these properties on every cycle:
- the FIFO count never exceeds four;
- the overflow flag stays set until a clear command;
- the interrupt never lasts two cycles;
- a FIFO-to-buffer move marks the buffer full;
- the serial output holds steady while no clock edge arrives;
- the self-stop never removes the enable while a byte is shifting.

Byte order, MSB-first bit order and the synchroniser latency can only be shown by the bench. So can the fill-level match for a given setting, the behaviour of the mode gate and the clear command in its interaction with the other stages. The bench shows these with a behavioural queue model compared on every clock and with whole bytes captured from the line.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE0   = 2'b00,
    MODE_IDLE1   = 2'b01,
    MODE_HALF_TX = 2'b10,
    MODE_FULL    = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    CMD_NONE0 = 2'b00,
    CMD_NONE1 = 2'b01,
    CMD_NONE2 = 2'b10,
    CMD_CLEAR = 2'b11
  } fifo_cmd_e;
endpackage

// File: rtl/sio_sclk_sync.sv
module sio_sclk_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= sclk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push, pop, ovf_q;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i & ~full & ~clr_i;
  assign pop     = pop_i & ~empty_o & ~clr_i;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr_i) cnt_nxt_o = '0;
    else       cnt_nxt_o = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (clr_i) begin
        rd_q  <= '0;
        wr_q  <= '0;
        ovf_q <= 1'b0;
      end else begin
        if (push) wr_q <= inc(wr_q);
        if (pop)  rd_q <= inc(rd_q);
        if (wr_i && full) ovf_q <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[i] <= '0;
      else if (push && wr_q == PW'(i))     mem_q[i] <= wr_data_i;
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/sio_tx_shifter.sv
module sio_tx_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pop_i,
  input  logic [W-1:0] head_i,
  input  logic         go_i,
  input  logic         fall_i,
  output logic         buf_valid_o,
  output logic         active_o,
  output logic         sdo_o
);
  logic [W-1:0]  buf_q, sh_q;
  logic          bufv_q, act_q;
  logic [BW-1:0] bit_q;
  logic          load;

  assign load = ~act_q & bufv_q & go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      bufv_q <= 1'b0;
    end else if (pop_i) begin
      buf_q  <= head_i;
      bufv_q <= 1'b1;
    end else if (load) begin
      bufv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b0;
      bit_q <= '0;
    end else if (load) begin
      sh_q  <= buf_q;
      act_q <= 1'b1;
      bit_q <= '0;
    end else if (act_q && fall_i) begin
      if (bit_q == BW'(W - 1)) begin
        act_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[W-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign buf_valid_o = bufv_q;
  assign active_o    = act_q;
  assign sdo_o       = act_q ? sh_q[W-1] : 1'b1;
endmodule

// File: rtl/sio_tx_queue.sv
module sio_tx_queue
  import sio_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              txe_wr_i,
  input  logic              txe_val_i,
  input  logic [1:0]        mode_i,
  input  logic [CW-1:0]     fill_lvl_i,
  input  logic              auto_dis_i,
  input  logic              cmd_stb_i,
  input  logic [1:0]        cmd_i,
  input  logic              sclk_i,
  output logic              sdo_o,
  output logic              buf_empty_o,
  output logic              tx_en_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic              sclk_fall, clr, pop, go;
  logic              fifo_empty, buf_valid, sh_active;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fifo_cnt, fifo_cnt_nxt;
  logic              tx_en_q, irq_q;

  assign clr = cmd_stb_i & (fifo_cmd_e'(cmd_i) == CMD_CLEAR);
  assign pop = ~buf_valid & ~fifo_empty & ~clr;
  assign go  = tx_en_q & (xfer_mode_e'(mode_i) == MODE_HALF_TX);

  sio_sclk_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (sclk_fall)
  );

  sio_tx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .pop_i     (pop),
    .clr_i     (clr),
    .head_o    (head),
    .cnt_o     (fifo_cnt),
    .cnt_nxt_o (fifo_cnt_nxt),
    .empty_o   (fifo_empty),
    .ovf_o     (ovf_o)
  );

  sio_tx_shifter #(.W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop),
    .head_i      (head),
    .go_i        (go),
    .fall_i      (sclk_fall),
    .buf_valid_o (buf_valid),
    .active_o    (sh_active),
    .sdo_o       (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= pop & (fifo_cnt_nxt == fill_lvl_i);
      if (txe_wr_i)
        tx_en_q <= txe_val_i;
      else if (auto_dis_i && fifo_empty && !buf_valid && !sh_active)
        tx_en_q <= 1'b0;
    end
  end

  assign tx_en_o     = tx_en_q;
  assign irq_o       = irq_q;
  assign buf_empty_o = ~buf_valid;
endmodule

// File: rtl/sio_tx_queue_chk.sv
module sio_tx_queue_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sdo_o,
  input logic          buf_empty_o,
  input logic          tx_en_o,
  input logic          ovf_o,
  input logic          irq_o,
  input logic          txe_wr_i,
  input logic [CW-1:0] fifo_cnt,
  input logic          sh_active,
  input logic          sclk_fall,
  input logic          pop,
  input logic          clr
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) fifo_cnt <= CW'(DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o && !clr |=> ovf_o); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni) clr |=> fifo_cnt == '0 && !ovf_o); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |=> !irq_o); // R7
  AST_BUF_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni) pop |=> !buf_empty_o); // R2
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) sh_active && !sclk_fall |=> $stable(sdo_o)); // R4
  AST_NO_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_en_o && sh_active && !txe_wr_i |=> tx_en_o); // R8
endmodule

bind sio_tx_queue sio_tx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdo_o       (sdo_o),
  .buf_empty_o (buf_empty_o),
  .tx_en_o     (tx_en_o),
  .ovf_o       (ovf_o),
  .irq_o       (irq_o),
  .txe_wr_i    (txe_wr_i),
  .fifo_cnt    (fifo_cnt),
  .sh_active   (sh_active),
  .sclk_fall   (sclk_fall),
  .pop         (pop),
  .clr         (clr)
);

// File: tb/sim_sio_tx_queue.sv
`timescale 1ns/1ps
module sim_sio_tx_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 0, txe_wr = 0, txe_val = 0, auto_dis = 0, cmd_stb = 0, sclk = 1;
  logic [7:0] wr_data = 0;
  logic [1:0] mode = 2'b10, cmd = 0;
  logic [2:0] fill_lvl = 0;
  logic       sdo, buf_empty, tx_en, ovf, irq;

  int checks = 0, fails = 0, cycles = 0, irq_seen = 0;

  always #5 clk = ~clk;

  sio_tx_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wr_data),
    .txe_wr_i(txe_wr), .txe_val_i(txe_val), .mode_i(mode), .fill_lvl_i(fill_lvl),
    .auto_dis_i(auto_dis), .cmd_stb_i(cmd_stb), .cmd_i(cmd), .sclk_i(sclk),
    .sdo_o(sdo), .buf_empty_o(buf_empty), .tx_en_o(tx_en), .ovf_o(ovf), .irq_o(irq)
  );

  // behavioural reference
  int   mq[$];
  bit   m_bufv, m_act, m_txen, m_ovf, m_irq, m_s1, m_s2, m_s3;
  int   m_buf, m_sh, m_bit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_bufv = 0; m_act = 0; m_txen = 0; m_ovf = 0; m_irq = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_buf = 0; m_sh = 0; m_bit = 0;
    end else begin
      bit fall, clr, pop, load, full0, empty0, bufv0, act0;
      int head;
      fall   = m_s3 && !m_s2;
      clr    = cmd_stb && cmd == 2'b11;
      full0  = mq.size() == 4;
      empty0 = mq.size() == 0;
      bufv0  = m_bufv;
      act0   = m_act;
      pop    = !bufv0 && !empty0 && !clr;
      load   = !act0 && bufv0 && m_txen && mode == 2'b10;
      head   = empty0 ? 0 : mq[0];
      if (clr) begin mq.delete(); m_ovf = 0; end
      else begin
        if (pop) void'(mq.pop_front());
        if (wr && full0) m_ovf = 1;
        else if (wr) mq.push_back(int'(wr_data));
      end
      m_irq = pop && mq.size() == int'(fill_lvl);
      if (load) begin m_sh = m_buf; m_act = 1; m_bit = 0; end
      else if (act0 && fall) begin
        if (m_bit == 7) m_act = 0;
        else begin m_sh = (m_sh << 1) & 8'hff; m_bit++; end
      end
      if (pop) begin m_buf = head; m_bufv = 1; end
      else if (load) m_bufv = 0;
      if (txe_wr) m_txen = txe_val;
      else if (auto_dis && empty0 && !bufv0 && !act0) m_txen = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sclk;
    end
  end

  function automatic bit m_sdo();
    return m_act ? m_sh[7] : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(sdo == m_sdo(), "R4 sdo vs model", sdo, m_sdo());
      chk(buf_empty == !m_bufv, "R2 buf_empty vs model", buf_empty, !m_bufv);
      chk(tx_en == m_txen, "R8 tx_en vs model", tx_en, m_txen);
      chk(ovf == m_ovf, "R3 ovf vs model", ovf, m_ovf);
      chk(irq == m_irq, "R7 irq vs model", irq, m_irq);
      if (irq) irq_seen++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    wr = 1; wr_data = d; tick(1); wr = 0;
  endtask

  task automatic set_en(input bit v);
    txe_wr = 1; txe_val = v; tick(1); txe_wr = 0;
  endtask

  task automatic clear_fifo();
    cmd_stb = 1; cmd = 2'b11; tick(1); cmd_stb = 0; cmd = 0;
  endtask

  // one serial byte: sample before each fall, 8 falls
  task automatic shift_byte(output logic [7:0] got);
    for (int b = 7; b >= 0; b--) begin
      got[b] = sdo;
      sclk = 0; tick(4); sclk = 1; tick(4);
    end
    tick(2);
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] exp_b [5];
    tick(3);
    chk(sdo == 1 && buf_empty && !tx_en && !ovf && !irq, "R1 reset state",
        {sdo, buf_empty, tx_en, ovf, irq}, 5'b11000);
    rst_n = 1; tick(2);

    // fill five, sixth overflows
    exp_b = '{8'hA5, 8'h3C, 8'hF0, 8'h81, 8'h5E};
    for (int i = 0; i < 5; i++) put(exp_b[i]);
    tick(2);
    chk(!buf_empty, "R2 buffer loaded from FIFO", buf_empty, 0);
    put(8'hEE);
    chk(ovf, "R3 overflow on full write", ovf, 1);
    tick(3);
    chk(ovf, "R3 overflow sticky", ovf, 1);

    // mode gate: enabled but mode 01
    mode = 2'b01; set_en(1); tick(3);
    sclk = 0; tick(4); sclk = 1; tick(4);
    chk(sdo == 1 && !buf_empty, "R6 mode 01 holds buffer, line idle", {sdo, buf_empty}, 2'b10);
    chk(sdo == 1, "R11 idle line high", sdo, 1);

    // transmit all five, auto-disable, level 0
    irq_seen = 0; fill_lvl = 0; auto_dis = 1; mode = 2'b10; tick(3);
    for (int i = 0; i < 5; i++) begin
      shift_byte(got);
      chk(got == exp_b[i], "R4 byte order MSB first", got, exp_b[i]);
      if (i < 4) chk(tx_en, "R8 enable kept while bytes remain", tx_en, 1);
    end
    tick(3);
    chk(!tx_en, "R8 auto-disable after last byte", tx_en, 0);
    chk(irq_seen == 1, "R7 level 0 interrupt count", irq_seen, 1);

    // latency: load one byte, count cycles after a fall
    put(8'h7F); tick(2); set_en(1); tick(3);
    chk(sdo == 0, "R5 first bit before fall", sdo, 0);
    sclk = 0; tick(2);
    chk(sdo == 0, "R5 unchanged two edges after fall", sdo, 0);
    tick(1);
    chk(sdo == 1, "R5 changed at third edge", sdo, 1);
    sclk = 1; tick(4);
    for (int b = 0; b < 7; b++) begin sclk = 0; tick(4); sclk = 1; tick(4); end
    tick(3);

    // clear: with write in same cycle, buffer kept
    auto_dis = 0; set_en(0);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
    cmd_stb = 1; cmd = 2'b11; wr = 1; wr_data = 8'h99; tick(1);
    cmd_stb = 0; wr = 0; tick(2);
    chk(!ovf, "R9 clear drops overflow", ovf, 0);
    chk(!buf_empty, "R9 buffer survives clear", buf_empty, 0);
    cmd_stb = 1; cmd = 2'b01; tick(1); cmd_stb = 0; cmd = 0;
    set_en(1); tick(3);
    shift_byte(got);
    chk(got == 8'h11, "R9 buffer byte sent after clear", got, 8'h11);
    tick(3);
    chk(buf_empty, "R9 discarded write left FIFO empty", buf_empty, 1);

    // level 2
    clear_fifo(); set_en(0); irq_seen = 0; fill_lvl = 2;
    for (int i = 0; i < 5; i++) put(8'(8'h40 + i));
    set_en(1); tick(3);
    for (int i = 0; i < 5; i++) shift_byte(got);
    chk(irq_seen == 1, "R7 level 2 interrupt count", irq_seen, 1);

    // host write beats auto-disable
    auto_dis = 1; tick(3);
    set_en(1);
    chk(tx_en, "R10 host write beats auto-disable", tx_en, 1);
    tick(2);
    chk(!tx_en, "R8 auto-disable with nothing queued", tx_en, 0);

    tick(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule